// File: doc/BRIEF.md
# Pseudo-SRAM Refresh Guard

A pseudo-SRAM refreshes its own cells, and it needs spare time to do so. A read pattern can take that time away. In that pattern the chip stays selected with the write strobe inactive, and the address keeps moving before a full read cycle has passed. If this goes on for more than about 15 µs, cell contents can be lost. This guard sits on the control path between a bus master and the memory. It measures, in clock cycles, how long such a run of short address intervals has lasted. Before the run reaches the limit, it breaks the run.

The run can be broken in one of two ways, chosen by a parameter:

- **Stall:** the guard raises `stall` toward the master. The master must then keep the address unchanged until `stall` drops. That is the back-pressure rule.
- **Chip-select pulse:** the guard forces the chip select seen by the memory high for one read-cycle time, with no help needed from the master.

A saturating counter reports how many corrective actions have been taken. The run timer restarts on any of these events:

- the address is held for a full read cycle,
- the chip select input goes high,
- a write cycle occurs.

Top module: `refresh_guard`

## Requirements
- R1: While `rst_n` is low, `stall` is 0, `fix_count` is 0 and `ce1_n_out` follows `ce1_n_in`.
- R2: Outside a chip-select pulse, `ce1_n_out` equals `ce1_n_in` in the same cycle.
- R3: The chip is read-selected when `ce1_n_in`=0 and `we_n_in`=1. Suppose the address changes on every cycle while the chip is read-selected, starting from an address that has been steady. Then the corrective action becomes visible after the THRESH+2-th rising edge counted from the cycle that first presents the new address, where THRESH = LIMIT_CYC − MARGIN_CYC. It is not visible after edge THRESH+1.
- R4: An address value kept on `addr_in` for RC_CYC+1 consecutive cycles restarts the run. A value kept for only RC_CYC cycles does not.
- R5: One cycle with `ce1_n_in`=1, or one cycle with `we_n_in`=0, restarts the run.
- R6: In stall mode (FIX_MODE=FIX_STALL), `stall` stays high until the address has been registered unchanged for RC_CYC edges, or until the chip leaves read selection. `ce1_n_out` is never altered in this mode.
- R7: In pulse mode (FIX_MODE=FIX_CE_PULSE), `ce1_n_out` is forced high for exactly RC_CYC cycles and `stall` stays 0. If the hazard continues, the next pulse starts RC_CYC+THRESH+1 edges after the previous one.
- R8: `fix_count` rises by exactly one at each corrective action and saturates at all ones.
- R9: While `stall` is low, the memory never sees more than LIMIT_CYC consecutive read-selected cycles without a steady address or a deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce1_n_in | input | 1 | Active-low chip select from the master |
| we_n_in | input | 1 | Active-low write strobe from the master |
| addr_in | input | ADDR_W | Word address from the master |
| ce1_n_out | output | 1 | Chip select driven to the memory |
| stall | output | 1 | Back-pressure: master must hold the address while high |
| fix_count | output | CNT_W | Saturating count of corrective actions |

## Verification
Suppose the run timer fails to restart on a steady address, a deselect or a write. The fault then shows as a `stall` or a chip-select pulse arriving tens of cycles early. Suppose instead the timer restarts when it should not. Then the action comes late, or never. The bench pins the first action to one exact cycle, so either fault shows within one threshold period. A pulse counter or release condition that is off by one shows at once in the measured width of the pulse or the stall. A broken `fix_count` shows on the cycle the action starts.

// File: rtl/refresh_guard_pkg.sv
package refresh_guard_pkg;
  typedef enum logic {
    FIX_STALL    = 1'b0,
    FIX_CE_PULSE = 1'b1
  } fix_mode_e;
endpackage

// File: rtl/rg_addr_tracker.sv
// Registers the address and counts edges since its last change.
module rg_addr_tracker #(
  parameter int ADDR_W = 21,
  parameter int RC_CYC = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              held_ok
);
  localparam int GAP_W = $clog2(RC_CYC + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [GAP_W-1:0]  gap_q;
  logic              moved;

  assign moved   = (addr_in != addr_q);
  assign held_ok = (gap_q == GAP_W'(RC_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      gap_q  <= '0;
    end else begin
      addr_q <= addr_in;
      if (moved)
        gap_q <= '0;
      else if (!held_ok)
        gap_q <= gap_q + GAP_W'(1);
    end
  end
endmodule

// File: rtl/rg_hazard_timer.sv
// Measures the length of a read run with short address intervals.
module rg_hazard_timer #(
  parameter int LIMIT_CYC  = 3750,
  parameter int MARGIN_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic read_sel,
  input  logic held_ok,
  input  logic fix_active,
  output logic trigger
);
  localparam int THRESH = LIMIT_CYC - MARGIN_CYC;
  localparam int TW     = $clog2(LIMIT_CYC + 1);

  logic [TW-1:0] run_q;

  assign trigger = (run_q == TW'(THRESH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_q <= '0;
    else if (!read_sel || held_ok || fix_active)
      run_q <= '0;
    else if (!trigger)
      run_q <= run_q + TW'(1);
  end
endmodule

// File: rtl/rg_fix_seq.sv
// Runs the corrective action chosen by FIX_MODE and counts actions.
module rg_fix_seq
  import refresh_guard_pkg::*;
#(
  parameter fix_mode_e FIX_MODE = FIX_STALL,
  parameter int        RC_CYC   = 18,
  parameter int        CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trigger,
  input  logic             held_ok,
  input  logic             read_sel,
  input  logic             ce1_n_in,
  output logic             fix_active,
  output logic             stall,
  output logic             ce1_n_out,
  output logic [CNT_W-1:0] fix_count
);
  logic             fix_q;
  logic             release_now;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (FIX_MODE == FIX_CE_PULSE) begin : g_pulse
      localparam int PW = $clog2(RC_CYC + 1);
      logic [PW-1:0] len_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          len_q <= '0;
        else if (!fix_q)
          len_q <= '0;
        else
          len_q <= len_q + PW'(1);
      end
      assign release_now = (len_q == PW'(RC_CYC - 1));
      assign ce1_n_out   = ce1_n_in | fix_q;
      assign stall       = 1'b0;
    end else begin : g_stall
      assign release_now = held_ok || !read_sel;
      assign ce1_n_out   = ce1_n_in;
      assign stall       = fix_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_q <= 1'b0;
      cnt_q <= '0;
    end else if (!fix_q) begin
      if (trigger) begin
        fix_q <= 1'b1;
        if (cnt_q != '1)
          cnt_q <= cnt_q + CNT_W'(1);
      end
    end else if (release_now) begin
      fix_q <= 1'b0;
    end
  end

  assign fix_active = fix_q;
  assign fix_count  = cnt_q;
endmodule

// File: rtl/refresh_guard.sv
module refresh_guard
  import refresh_guard_pkg::*;
#(
  parameter int        ADDR_W     = 21,
  parameter int        RC_CYC     = 18,
  parameter int        LIMIT_CYC  = 3750,
  parameter int        MARGIN_CYC = 250,
  parameter int        CNT_W      = 16,
  parameter fix_mode_e FIX_MODE   = FIX_STALL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce1_n_in,
  input  logic              we_n_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              ce1_n_out,
  output logic              stall,
  output logic [CNT_W-1:0]  fix_count
);
  logic read_sel;
  logic held_ok;
  logic trigger;
  logic fix_active;

  assign read_sel = !ce1_n_in && we_n_in;

  rg_addr_tracker #(.ADDR_W(ADDR_W), .RC_CYC(RC_CYC)) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_in (addr_in),
    .held_ok (held_ok)
  );

  rg_hazard_timer #(.LIMIT_CYC(LIMIT_CYC), .MARGIN_CYC(MARGIN_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .read_sel   (read_sel),
    .held_ok    (held_ok),
    .fix_active (fix_active),
    .trigger    (trigger)
  );

  rg_fix_seq #(.FIX_MODE(FIX_MODE), .RC_CYC(RC_CYC), .CNT_W(CNT_W)) u_fix (
    .clk        (clk),
    .rst_n      (rst_n),
    .trigger    (trigger),
    .held_ok    (held_ok),
    .read_sel   (read_sel),
    .ce1_n_in   (ce1_n_in),
    .fix_active (fix_active),
    .stall      (stall),
    .ce1_n_out  (ce1_n_out),
    .fix_count  (fix_count)
  );
endmodule

// File: rtl/refresh_guard_chk.sv
module refresh_guard_chk
  import refresh_guard_pkg::*;
#(
  parameter int        ADDR_W     = 21,
  parameter int        RC_CYC     = 18,
  parameter int        LIMIT_CYC  = 3750,
  parameter int        CNT_W      = 16,
  parameter fix_mode_e FIX_MODE   = FIX_STALL
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce1_n_in,
  input logic              we_n_in,
  input logic [ADDR_W-1:0] addr_in,
  input logic              ce1_n_out,
  input logic              stall,
  input logic [CNT_W-1:0]  fix_count
);
  localparam int SW = $clog2(RC_CYC + 1);
  localparam int RW = $clog2(LIMIT_CYC + 2);

  logic [ADDR_W-1:0] a_prev;
  logic [SW-1:0]     steady_q;
  logic [RW-1:0]     dev_run_q;

  // Independent view of what the memory sees on its own pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev    <= '0;
      steady_q  <= '0;
      dev_run_q <= '0;
    end else begin
      a_prev <= addr_in;
      if (addr_in != a_prev)
        steady_q <= '0;
      else if (steady_q != SW'(RC_CYC))
        steady_q <= steady_q + SW'(1);
      if (ce1_n_out || !we_n_in || steady_q == SW'(RC_CYC))
        dev_run_q <= '0;
      else if (!stall && dev_run_q != RW'(LIMIT_CYC + 1))
        dev_run_q <= dev_run_q + RW'(1);
    end
  end

  // R9: the memory never sees an over-long run without a break
  assert_run_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dev_run_q <= RW'(LIMIT_CYC));

  // R8: the count only ever steps up by one
  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_count != $past(fix_count)) |-> (fix_count == $past(fix_count) + CNT_W'(1)));

  // R3: a stall starts only during a read-selected period
  assert_stall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(!ce1_n_in && we_n_in));

  // R6: a stall ends only after a steady address or a leave of read selection
  assert_stall_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stall) |-> ($past(steady_q) == SW'(RC_CYC) || $past(ce1_n_in) || !$past(we_n_in)));

  // R7: a forced chip-select rise is always a counted action
  assert_pulse_counted_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (FIX_MODE == FIX_CE_PULSE && $rose(ce1_n_out) && !ce1_n_in)
      |-> (fix_count != $past(fix_count) || fix_count == '1));
endmodule

bind refresh_guard refresh_guard_chk #(
  .ADDR_W(ADDR_W), .RC_CYC(RC_CYC), .LIMIT_CYC(LIMIT_CYC),
  .CNT_W(CNT_W), .FIX_MODE(FIX_MODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce1_n_in(ce1_n_in), .we_n_in(we_n_in),
  .addr_in(addr_in), .ce1_n_out(ce1_n_out), .stall(stall), .fix_count(fix_count)
);

// File: tb/refresh_guard_test.sv
`timescale 1ns/1ps
module refresh_guard_test;
  import refresh_guard_pkg::*;

  localparam int RC  = 4;
  localparam int LIM = 48;
  localparam int MAR = 8;
  localparam int T   = LIM - MAR;
  localparam int P   = RC + T + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ce_n = 1'b1;
  logic       we_n = 1'b1;
  logic [7:0] addr = '0;

  logic        ce_s, stall_s, ce_p, stall_p;
  logic [15:0] cnt_s;
  logic [1:0]  cnt_p;

  always #2 clk = ~clk;

  refresh_guard #(.ADDR_W(8), .RC_CYC(RC), .LIMIT_CYC(LIM), .MARGIN_CYC(MAR),
                  .CNT_W(16), .FIX_MODE(FIX_STALL)) uut (
    .clk(clk), .rst_n(rst_n), .ce1_n_in(ce_n), .we_n_in(we_n), .addr_in(addr),
    .ce1_n_out(ce_s), .stall(stall_s), .fix_count(cnt_s));

  refresh_guard #(.ADDR_W(8), .RC_CYC(RC), .LIMIT_CYC(LIM), .MARGIN_CYC(MAR),
                  .CNT_W(2), .FIX_MODE(FIX_CE_PULSE)) uut_pulse (
    .clk(clk), .rst_n(rst_n), .ce1_n_in(ce_n), .we_n_in(we_n), .addr_in(addr),
    .ce1_n_out(ce_p), .stall(stall_p), .fix_count(cnt_p));

  typedef struct {
    string tag;
    int    sel;
    int    exp;
    int    iter;
  } item_t;

  item_t sb[$];
  item_t pend[$];
  int n_run  = 0;
  int n_fail = 0;

  task automatic report(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int probe(int sel);
    case (sel)
      0: return int'(stall_s);
      1: return int'(ce_s);
      2: return int'(cnt_s);
      3: return int'(stall_p);
      4: return int'(ce_p);
      default: return int'(cnt_p);
    endcase
  endfunction

  // Monitor: compares queued expectations at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      report(it.tag, probe(it.sel), it.exp);
    end
  end

  task automatic plan(int iter, string tag, int sel, int exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp; it.iter = iter;
    pend.push_back(it);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; addr = '0;
    pend.delete();
    repeat (3) step();
    rst_n = 1'b1;
    ce_n  = 1'b0;
    repeat (RC + 3) step();
  endtask

  // Driver: new address every cycle, with an optional hold and break.
  task automatic run(int len, int hold_at, int hold_len, int brk_at, int brk_kind);
    for (int i = 1; i <= len; i++) begin
      step();
      if (!(hold_len > 0 && i > hold_at && i < hold_at + hold_len))
        addr = addr + 8'd1;
      ce_n = (brk_kind == 1 && i == brk_at);
      we_n = !(brk_kind == 2 && i == brk_at);
      for (int k = pend.size() - 1; k >= 0; k--) begin
        if (pend[k].iter == i) begin
          sb.push_back(pend[k]);
          pend.delete(k);
        end
      end
    end
    @(negedge clk);
    #0.5;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int len;
    bit ce_moved;
    // R1 reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    report("R1 stall in reset", int'(stall_s), 0);
    report("R1 count in reset", int'(cnt_s), 0);
    report("R1 ce follows in reset", int'(ce_s), 1);
    ce_n = 1'b0;
    #0.5;
    report("R1 ce follows low in reset", int'(ce_p), 0);
    // R2 pass-through
    do_reset();
    @(negedge clk);
    report("R2 ce low passes", int'(ce_s), 0);
    step(); ce_n = 1'b1;
    @(negedge clk);
    report("R2 ce high passes", int'(ce_p), 1);

    // R3, R7, R8: continuous hazard
    do_reset();
    plan(T + 2, "R3 stall not yet", 0, 0);
    plan(T + 3, "R3 stall rises", 0, 1);
    plan(T + 3, "R8 stall count 1", 2, 1);
    plan(T + 2, "R7 no pulse yet", 4, 0);
    plan(T + 3, "R7 pulse starts", 4, 1);
    plan(T + 3, "R7 no stall in pulse mode", 3, 0);
    plan(T + 2 + RC, "R7 pulse still high", 4, 1);
    plan(T + 3 + RC, "R7 pulse ends", 4, 0);
    plan(T + 2 + P, "R7 gap before second", 4, 0);
    plan(T + 3 + P, "R7 second pulse", 4, 1);
    plan(T + 3 + P, "R8 pulse count 2", 5, 2);
    plan(T + 3 + P, "R6 stall holds while address moves", 0, 1);
    plan(T + 3 + P, "R8 one stall counted", 2, 1);
    plan(T + 3 + 2 * P, "R8 pulse count 3", 5, 3);
    plan(T + 3 + 3 * P, "R7 fourth pulse", 4, 1);
    plan(T + 4 + 3 * P, "R8 count saturates", 5, 3);
    run(T + 5 + 3 * P, 0, 0, 0, 0);

    // R6: obeying master, stall length
    do_reset();
    plan(T + 3, "R3 stall rises again", 0, 1);
    run(T + 3, 0, 0, 0, 0);
    len = 1;
    ce_moved = 1'b0;
    for (int g = 0; g < 20; g++) begin
      step();
      @(negedge clk);
      if (ce_s) ce_moved = 1'b1;
      if (!stall_s) break;
      len++;
    end
    report("R6 stall length", len, RC + 2);
    report("R6 ce untouched in stall mode", int'(ce_moved), 0);
    report("R8 single stall counted", int'(cnt_s), 1);

    // R4: hold for RC cycles does not clear
    do_reset();
    plan(T + 2, "R4 short hold no early stall", 0, 0);
    plan(T + 3, "R4 short hold keeps run", 0, 1);
    run(T + 4, 10, RC, 0, 0);

    // R4: hold for RC+1 cycles clears
    do_reset();
    plan(T + 3, "R4 long hold cleared run", 0, 0);
    plan(10 + RC + 2 + T, "R4 restart not yet", 0, 0);
    plan(10 + RC + 3 + T, "R4 restarted run stalls", 0, 1);
    plan(10 + RC + 3 + T, "R4 restarted run pulses", 4, 1);
    run(10 + RC + 4 + T, 10, RC + 1, 0, 0);

    // R5: one chip-select high cycle
    do_reset();
    plan(10, "R2 ce high cycle passes", 1, 1);
    plan(T + 3, "R5 deselect cleared run", 0, 0);
    plan(11 + T, "R5 deselect restart not yet", 0, 0);
    plan(12 + T, "R5 deselect restart stalls", 0, 1);
    plan(12 + T, "R5 deselect restart pulses", 4, 1);
    run(13 + T, 0, 0, 10, 1);

    // R5: one write cycle
    do_reset();
    plan(T + 3, "R5 write cleared run", 4, 0);
    plan(11 + T, "R5 write restart not yet", 0, 0);
    plan(12 + T, "R5 write restart stalls", 0, 1);
    run(13 + T, 0, 0, 10, 2);

    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule